// File: doc/BRIEF.md
# Three-Wire Serial Register Transaction Engine

This block is the link layer between a controller and a peripheral whose registers are reached over a three-wire serial link. The link has a serial clock, an active-low select and a single data line that both ends drive in turn. A requester hands the block one transaction at a time: a direction flag, a 7-bit register address, one data byte for writes, and the number of bytes to collect for reads. The block wraps each transaction in its own select frame and shifts out a command byte. For a write it then shifts out the data byte. For a read it releases the data line, waits a programmable turnaround, and clocks in one or more bytes, presenting each one on a single-cycle strobe.

The serial clock idles high. Each bit is placed on the line while the clock is low, and it is captured on the rising clock edge. Bytes travel most-significant bit first. The command byte sets bit 7 for a write and clears it for a read. Bits 6:0 hold the address. A multi-byte read, for example the three-byte motion burst at address 0x63, stays within one frame. The same gap length that sets the turnaround also sets the minimum idle time between frames. Scheduling of transactions and the meaning of register contents are left to the requester.

Top module: `tw_xact_engine`

## Requirements
- R1: Out of reset and whenever no frame is open, `cs_n` is 1, `sclk` is 1, `sdio_oe` is 0 and `busy` is 0.
- R2: The first byte of every frame is the command {req_write, req_addr[6:0]} (bit 7 = 1 for write, 0 for read), sent MSB first. Each bit changes only when `sclk` falls and is held while `sclk` is high, so the peripheral samples it on the rising edge.
- R3: A write frame carries exactly 16 rising `sclk` edges: the command, then `req_wdata` MSB first, with `sdio_oe` high on every one of them. Writing 0x5A to 0x3A therefore sends 0xBA then 0x5A.
- R4: In a read frame `sdio_oe` is 0 at every rising edge after the eighth. `sdio_in` is captured on each of those rising edges, MSB first, and the frame carries 8 + 8·N rising edges.
- R5: N equals `req_nbytes`, and a value of 0 is taken as 1. A read of address 0x63 with N = 3 returns three consecutive bytes inside one frame.
- R6: Each read byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in arrival order, and `rd_valid` is only ever 1 while `cs_n` is 0 and the line is released.
- R7: Every accepted request produces exactly one frame. `cs_n` falls while `sclk` is high, before the first falling clock edge, and it rises only after `sclk` has returned high after the last rising edge.
- R8: In a read, `sclk` stays high for at least HALF_DIV + `gap_len` system cycles between the eighth rising edge and the next falling edge.
- R9: Between the rise of `cs_n` that ends one frame and the fall that opens the next, `cs_n` stays high for at least `gap_len` system cycles.
- R10: A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` is 1 from the cycle after acceptance until the cycle in which `cs_n` rises. Requests presented while `busy` is 1 produce no frame and no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Data byte for writes |
| req_nbytes | input | NB_W | Bytes to read (0 taken as 1) |
| gap_len | input | GAP_W | Turnaround and inter-frame gap in system cycles |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | One-cycle strobe per read byte |
| rd_data | output | 8 | Read byte |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low select, one frame per transaction |
| sdio_out | output | 1 | Data line value when driving |
| sdio_oe | output | 1 | Data line drive enable |
| sdio_in | input | 1 | Data line value from the peripheral |

## Verification
If the sequencer's phase is wrong, for instance if it treats a read as a write, the symptom appears within the same frame. The rising-edge count at the select rise comes out wrong, or the drive enable is seen high after the eighth rising edge. A wrong bit counter or a wrong byte counter shows up as a bad command byte, a bad data byte or a missing read strobe by the time that frame closes. If the gap timer is loaded wrongly, the turnaround is too short at the ninth falling edge, or the select is held high for too few cycles at the next frame's falling edge. A busy flag that drops early shows up one frame later, as an extra frame that matches no queued request.

// File: rtl/tw_xact_pkg.sv
package tw_xact_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TURN
    } tw_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WDATA,
        PH_RDATA
    } tw_phase_e;

    typedef struct packed {
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } tw_req_t;

    function automatic logic [BYTE_W-1:0] cmd_byte(input logic wr, input logic [ADDR_W-1:0] addr);
        return {wr, addr};
    endfunction

endpackage

// File: rtl/tw_timer.sv
module tw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/tw_xact_engine.sv
module tw_xact_engine
    import tw_xact_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_W    = 8,
    parameter int NB_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic [NB_W-1:0]   req_nbytes,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              busy,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic              sdio_in
);
    localparam int HB_W  = $clog2(HALF_DIV) + 1;
    localparam int TMR_W = (GAP_W > HB_W) ? GAP_W : HB_W;
    localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(HALF_DIV - 1);
    localparam logic [TMR_W-1:0] GAP_Z   = '0;

    tw_state_e         state;
    tw_phase_e         phase;
    tw_req_t           req_q;
    logic [NB_W-1:0]   left;
    logic [2:0]        bit_cnt;
    logic              sclk_q, cs_q, oe_q, dout_q, busy_q, rdv_q;
    logic [BYTE_W-1:0] rdd_q;

    logic              t_ld, t_done;
    logic [TMR_W-1:0]  t_val;
    logic              s_ld, s_sh;
    logic [BYTE_W-1:0] s_val, s_q;
    logic              accept, byte_end;

    assign accept   = req_valid && !busy_q;
    assign byte_end = (bit_cnt == 3'd7);

    tw_timer #(.W(TMR_W)) tmr_i (
        .clk(clk), .rst(rst), .load(t_ld), .load_val(t_val), .done(t_done)
    );

    tw_shift #(.W(BYTE_W)) shf_i (
        .clk(clk), .rst(rst), .load(s_ld), .load_val(s_val),
        .shift(s_sh), .sin(sdio_in), .q(s_q)
    );

    // Timer and shifter controls
    always_comb begin
        t_ld  = 1'b0;
        t_val = HALF_LD;
        s_ld  = 1'b0;
        s_val = req_wdata;
        s_sh  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    s_ld  = 1'b1;
                    s_val = cmd_byte(req_write, req_addr);
                end
            end
            ST_PRE, ST_SETUP, ST_TURN: begin
                t_ld = t_done;
            end
            ST_LOW: begin
                t_ld = t_done;
                s_sh = t_done;
            end
            ST_HIGH: begin
                if (t_done) begin
                    t_ld = 1'b1;
                    if (byte_end) begin
                        unique case (phase)
                            PH_CMD: begin
                                if (req_q.wr) begin
                                    s_ld  = 1'b1;
                                    s_val = req_q.wdata;
                                end else begin
                                    t_val = GAP_Z | TMR_W'(gap_len);
                                end
                            end
                            PH_WDATA: t_val = GAP_Z | TMR_W'(gap_len);
                            default:  t_val = (left > NB_W'(1)) ? HALF_LD : (GAP_Z | TMR_W'(gap_len));
                        endcase
                    end
                end
            end
            default: ;
        endcase
    end

    // Sequencer and pin registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_CMD;
            req_q   <= '0;
            left    <= '0;
            bit_cnt <= '0;
            sclk_q  <= 1'b1;
            cs_q    <= 1'b1;
            oe_q    <= 1'b0;
            dout_q  <= 1'b0;
            busy_q  <= 1'b0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            rdv_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req_q.wr    <= req_write;
                        req_q.wdata <= req_wdata;
                        left        <= (req_nbytes == '0) ? NB_W'(1) : req_nbytes;
                        busy_q      <= 1'b1;
                        phase       <= PH_CMD;
                        state       <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (t_done) begin
                        cs_q    <= 1'b0;
                        oe_q    <= 1'b1;
                        bit_cnt <= '0;
                        state   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (t_done) begin
                        sclk_q <= 1'b0;
                        dout_q <= s_q[BYTE_W-1];
                        state  <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (t_done) begin
                        sclk_q <= 1'b1;
                        if (phase == PH_RDATA && byte_end) begin
                            rdv_q <= 1'b1;
                            rdd_q <= {s_q[BYTE_W-2:0], sdio_in};
                        end
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (t_done) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (!byte_end) begin
                            sclk_q <= 1'b0;
                            dout_q <= s_q[BYTE_W-1];
                            state  <= ST_LOW;
                        end else begin
                            unique case (phase)
                                PH_CMD: begin
                                    if (req_q.wr) begin
                                        phase  <= PH_WDATA;
                                        sclk_q <= 1'b0;
                                        dout_q <= req_q.wdata[BYTE_W-1];
                                        state  <= ST_LOW;
                                    end else begin
                                        phase  <= PH_RDATA;
                                        oe_q   <= 1'b0;
                                        dout_q <= 1'b0;
                                        state  <= ST_TURN;
                                    end
                                end
                                PH_RDATA: begin
                                    if (left > NB_W'(1)) begin
                                        left   <= left - NB_W'(1);
                                        sclk_q <= 1'b0;
                                        state  <= ST_LOW;
                                    end else begin
                                        cs_q   <= 1'b1;
                                        busy_q <= 1'b0;
                                        state  <= ST_IDLE;
                                    end
                                end
                                default: begin
                                    cs_q   <= 1'b1;
                                    oe_q   <= 1'b0;
                                    dout_q <= 1'b0;
                                    busy_q <= 1'b0;
                                    state  <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                end
                ST_TURN: begin
                    if (t_done) begin
                        sclk_q <= 1'b0;
                        state  <= ST_LOW;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = busy_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;
    assign sclk     = sclk_q;
    assign cs_n     = cs_q;
    assign sdio_out = dout_q;
    assign sdio_oe  = oe_q;
endmodule

// File: rtl/tw_xact_chk.sv
module tw_xact_chk #(
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             busy,
    input logic             rd_valid,
    input logic             sclk,
    input logic             cs_n,
    input logic             sdio_out,
    input logic             sdio_oe,
    input logic [GAP_W-1:0] gap_len
);
    logic [GAP_W:0] hi_cnt;
    logic           armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            armed  <= 1'b0;
        end else if (!cs_n) begin
            hi_cnt <= '0;
            armed  <= 1'b1;
        end else if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (sclk && !sdio_oe));

    p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe && $past(sdio_oe) && !$fell(sclk)) |-> $stable(sdio_out));

    p_strobe_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!cs_n && !sdio_oe));

    p_open_clk_high_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> sclk);

    p_close_clk_high_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (sclk && $past(sclk)));

    p_frame_gap_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && armed) |-> (hi_cnt >= {1'b0, gap_len}));

    p_busy_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);
endmodule

bind tw_xact_engine tw_xact_chk #(.GAP_W(GAP_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
    .rd_valid(rd_valid), .sclk(sclk), .cs_n(cs_n), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .gap_len(gap_len)
);

// File: tb/tw_xact_engine_tb_top.sv
module tw_xact_engine_tb_top;
    localparam int HALF_DIV = 2;
    localparam int GAP_W    = 8;
    localparam int NB_W     = 2;
    localparam int GAP      = 5;

    typedef struct {
        logic [7:0] cmd;
        logic [7:0] wd;
        int         edges;
    } frame_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [6:0]       req_addr = '0;
    logic [7:0]       req_wdata = '0;
    logic [NB_W-1:0]  req_nbytes = '0;
    logic [GAP_W-1:0] gap_len = GAP_W'(GAP);
    logic             busy, rd_valid, sclk, cs_n, sdio_out, sdio_oe;
    logic [7:0]       rd_data;
    logic             sdio_in = 1'b0;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit rst_done = 0, seen_rise = 0, finished = 0;
    int t_rise = 0, t_cmd = 0, bitpos = 0;
    logic [7:0] cmd_cap = '0, wd_cap = '0;
    bit oe_bad = 0, busy_bad = 0;

    frame_t     exp_fr[$];
    logic [7:0] exp_rd[$];

    always #10 clk = ~clk;

    tw_xact_engine #(.HALF_DIV(HALF_DIV), .GAP_W(GAP_W), .NB_W(NB_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_nbytes(req_nbytes),
        .gap_len(gap_len), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sclk(sclk), .cs_n(cs_n), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdio_in(sdio_in)
    );

    function automatic logic [7:0] resp(input logic [6:0] a, input int idx);
        return {a, 1'b1} ^ (8'h3C + 8'(idx) * 8'h51);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [6:0] a, input logic [7:0] wd, input logic [NB_W-1:0] n);
        frame_t f;
        int nb;
        nb = (n == 0) ? 1 : int'(n);
        f.cmd = {wr, a};
        f.wd = wd;
        f.edges = wr ? 16 : 8 + 8 * nb;
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_fr.push_back(f);
        if (!wr) for (int i = 0; i < nb; i++) exp_rd.push_back(resp(a, i));
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_nbytes = n;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    endtask

    // Cycle counter and per-cycle monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_done) begin
            if (!cs_n && !busy) busy_bad = 1;
            if (rd_valid) begin
                if (exp_rd.size() == 0) begin
                    chk(0, "R6 unexpected read strobe", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_rd.pop_front();
                    chk(rd_data == e, "R5 read byte", rd_data, e);
                end
                chk(!cs_n, "R6 strobe inside frame", cs_n, 0);
            end
        end
    end

    // Peripheral model
    always @(negedge cs_n) begin
        if (rst_done) begin
            if (seen_rise) chk(cyc - t_rise >= GAP, "R9 select high time", cyc - t_rise, GAP);
            chk(sclk == 1'b1, "R7 clock high at frame open", sclk, 1);
            bitpos = 0; cmd_cap = '0; wd_cap = '0; oe_bad = 0; busy_bad = 0;
        end
    end

    always @(posedge sclk) begin
        if (rst_done && !cs_n) begin
            if (bitpos < 8) begin
                cmd_cap = {cmd_cap[6:0], sdio_out};
                if (!sdio_oe) oe_bad = 1;
            end else if (cmd_cap[7]) begin
                wd_cap = {wd_cap[6:0], sdio_out};
                if (!sdio_oe) oe_bad = 1;
            end else if (sdio_oe) begin
                oe_bad = 1;
            end
            bitpos++;
            if (bitpos == 8) t_cmd = cyc;
        end
    end

    always @(negedge sclk) begin
        if (rst_done && !cs_n && !cmd_cap[7] && bitpos >= 8) begin
            logic [7:0] b;
            if (bitpos == 8)
                chk(cyc - t_cmd >= HALF_DIV + GAP, "R8 turnaround", cyc - t_cmd, HALF_DIV + GAP);
            b = resp(cmd_cap[6:0], (bitpos - 8) / 8);
            sdio_in = b[7 - ((bitpos - 8) % 8)];
        end
    end

    always @(posedge cs_n) begin
        if (rst_done) begin
            t_rise = cyc;
            seen_rise = 1;
            sdio_in = 1'b0;
            if (exp_fr.size() == 0) begin
                chk(0, "R10 frame with no accepted request", cmd_cap, 0);
            end else begin
                frame_t f;
                f = exp_fr.pop_front();
                chk(cmd_cap == f.cmd, "R2 command byte", cmd_cap, f.cmd);
                if (f.cmd[7]) chk(wd_cap == f.wd, "R3 write byte", wd_cap, f.wd);
                chk(bitpos == f.edges, "R4 rising edges per frame", bitpos, f.edges);
                chk(!oe_bad, "R4 drive enable per phase", oe_bad, 0);
                chk(!busy_bad, "R10 busy during frame", busy_bad, 0);
            end
            @(negedge clk);
            chk(busy == 1'b0 && sdio_oe == 1'b0, "R1 idle after frame", {busy, sdio_oe}, 0);
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "R7 watchdog expired", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rst_done = 1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset select", cs_n, 1);
        chk(sclk == 1'b1, "R1 reset clock", sclk, 1);
        chk(sdio_oe == 1'b0, "R1 reset drive enable", sdio_oe, 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 reset busy/strobe", {busy, rd_valid}, 0);

        do_req(1'b1, 7'h3A, 8'h5A, 2'd0);     // R3 write
        do_req(1'b0, 7'h00, 8'h00, 2'd1);     // R4 single read
        do_req(1'b0, 7'h63, 8'h00, 2'd3);     // R5 burst of three
        do_req(1'b0, 7'h1A, 8'h00, 2'd0);     // R5 zero count means one
        do_req(1'b1, 7'h0D, 8'h86, 2'd0);
        // R10: request while busy is ignored
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 7'h55; req_nbytes = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        do_req(1'b1, 7'h7F, 8'h00, 2'd0);     // R2 boundary address
        do_req(1'b1, 7'h00, 8'hFF, 2'd0);
        do_req(1'b0, 7'h7F, 8'h00, 2'd2);

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(exp_fr.size() == 0, "R7 frames outstanding", exp_fr.size(), 0);
        chk(exp_rd.size() == 0, "R6 read bytes outstanding", exp_rd.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule